// File: doc/BRIEF.md
# T1 Receive Two-Frame Slip Buffer

This block sits between a T1 line receiver and a 32-slot, 2.048 Mb/s backplane. The line side delivers one bit per strobe together with a pulse that marks the framing bit. Each 193-bit frame is split into 24 channel bytes and stored in one half of a two-frame store. The backplane side asks for one byte per slot strobe and gets the channel bytes in slots 0 to 23 and an idle fill in the remaining slots. Both sides run on one fast clock with separate enable strobes, so the line rate and the backplane rate are set by how often each strobe fires.

At every backplane frame boundary the block measures how far the writer has advanced into the store, relative to the start of the frame the reader is about to read. While that distance stays within 140 bit periods of its mid-range value, the reader moves to the other half as usual. When the distance leaves that window, the reader stays on the half it has just read. This either repeats that frame or deletes the next one, so the slip is always exactly one frame and channel alignment is kept. Every slip is reported with a single-cycle pulse, a direction flag and a sticky status bit.

Top module: `t1_rx_slip_buf`

## Requirements
- R1: After reset, `pcm_valid_o`, `slip_o`, `slip_drop_o` and `slip_seen_o` are all low.
- R2: A line strobe with `line_fs` high carries the framing bit, which is discarded. The next 192 strobed bits form channel bytes 0 to 23 in order, most significant bit first. The first frame after reset goes to store half 0, and each later frame start switches to the other half.
- R3: Every `sys_slot_en` strobe produces exactly one byte on `pcm_data_o`, with `pcm_valid_o` high in the following cycle. A strobe with `sys_fs` high is slot 0; otherwise the slot number advances by one and wraps after slot 31.
- R4: Slot n (0 to 23) carries channel n of the half being read. Slots 24 to 31 carry 8'hFF.
- R5: Reading begins one frame behind writing: the first backplane frame after reset reads store half 0.
- R6: At each slot 0, the phase is defined as the position (0 to 385) of the most recently written line bit, minus the start (0 for half 0, 193 for half 1) of the half the reader would move to, taken modulo 386. A phase from 53 to 333 moves the reader to the other half without a slip. When the two timings are locked, no slip occurs.
- R7: A phase below 53 repeats the frame just read (the reader stays on its half). This raises a slip with `slip_drop_o` = 0.
- R8: A phase above 333 deletes a frame (the reader stays on its half, skipping the other). This raises a slip with `slip_drop_o` = 1.
- R9: `slip_o` is high for exactly the one cycle in which slot 0's byte is presented. `slip_drop_o` holds the direction of the last slip.
- R10: `slip_seen_o` goes high with every slip and stays high until `slip_clr` is asserted with no slip in the same cycle. A slip wins over a clear in the same cycle.
- R11: Until the first line frame start after reset, no slip decision is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_bit_en | input | 1 | Line bit strobe |
| line_fs | input | 1 | Marks the strobed bit as the framing bit |
| line_bit | input | 1 | Received line bit |
| sys_slot_en | input | 1 | Backplane slot strobe |
| sys_fs | input | 1 | Marks the strobed slot as slot 0 |
| slip_clr | input | 1 | Clears the sticky slip status |
| pcm_data_o | output | 8 | Byte for the strobed slot |
| pcm_valid_o | output | 1 | `pcm_data_o` is valid |
| slip_o | output | 1 | One-cycle slip pulse |
| slip_drop_o | output | 1 | Direction of last slip: 1 deleted, 0 repeated |
| slip_seen_o | output | 1 | Sticky slip status |

## Verification
The bench first runs the two sides locked for several frames. A design that slipped without cause, or that started reading in the half being written, would show wrong bytes or a stray slip pulse. It then slows the line side until the phase falls below the lower limit, and speeds it up until the phase passes the upper limit. A design that moved the read pointer the wrong way, or that reversed the direction flag, would show misaligned channels or a wrong `slip_drop_o`. Idle slots, bit order and the sticky clear are each checked at the ports, so a swapped shift direction, a missed fill, or a clear that lost to a slip would all be reported.

// File: rtl/t1sb_pkg.sv
package t1sb_pkg;

   typedef enum logic {
      SLIP_REPEAT = 1'b0,
      SLIP_DELETE = 1'b1
   } slip_dir_e;

   function automatic int frame_bits(input int ch, input int bw);
      return ch * bw + 1;
   endfunction

endpackage

// File: rtl/t1sb_wr.sv
module t1sb_wr #(
   parameter int CH        = 24,
   parameter int BW        = 8,
   parameter bit MSB_FIRST = 1'b1,
   localparam int FB       = t1sb_pkg::frame_bits(CH, BW),
   localparam int PW       = $clog2(2 * FB),
   localparam int AW       = $clog2(2 * CH),
   localparam int FBW      = $clog2(FB),
   localparam int CW       = $clog2(CH + 1),
   localparam int BTW      = $clog2(BW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  logic          fs,
   input  logic          bit_i,
   output logic          we_o,
   output logic [AW-1:0] waddr_o,
   output logic [BW-1:0] wdata_o,
   output logic [PW-1:0] wpos_o,
   output logic          synced_o
);

   logic [FBW-1:0] wbit;
   logic           wpar;
   logic           synced;
   logic [CW-1:0]  wch;
   logic [BTW-1:0] wbt;
   logic [BW-1:0]  sh, nxt_sh;
   logic           last_bit, data_bit;

   assign last_bit = (wbit == FBW'(FB - 1));
   assign data_bit = bit_en && synced && !fs && !last_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign nxt_sh = {sh[BW-2:0], bit_i};
      end else begin : g_lsb
         assign nxt_sh = {bit_i, sh[BW-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbit   <= '0;
         wpar   <= 1'b0;
         synced <= 1'b0;
         wch    <= '0;
         wbt    <= '0;
         sh     <= '0;
      end else if (bit_en) begin
         if (fs) begin
            synced <= 1'b1;
            wpar   <= synced & ~wpar;
            wbit   <= '0;
            wch    <= '0;
            wbt    <= '0;
         end else if (synced) begin
            if (last_bit) begin
               wbit <= '0;
               wpar <= ~wpar;
               wch  <= '0;
               wbt  <= '0;
            end else begin
               wbit <= wbit + 1'b1;
               sh   <= nxt_sh;
               if (wbt == BTW'(BW - 1)) begin
                  wbt <= '0;
                  wch <= wch + 1'b1;
               end else begin
                  wbt <= wbt + 1'b1;
               end
            end
         end
      end
   end

   assign we_o     = data_bit && (wbt == BTW'(BW - 1));
   assign wdata_o  = nxt_sh;
   assign waddr_o  = wpar ? AW'(CH) + AW'(wch) : AW'(wch);
   assign wpos_o   = wpar ? PW'(FB) + PW'(wbit) : PW'(wbit);
   assign synced_o = synced;

   AST_WPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wpos_o < PW'(2 * FB)); // R6
   AST_WRITE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> synced_o); // R2

endmodule

// File: rtl/t1sb_store.sv
module t1sb_store #(
   parameter int DEPTH = 48,
   parameter int BW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [BW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [BW-1:0] rdata
);

   logic [BW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/t1sb_rd.sv
module t1sb_rd #(
   parameter int          CH        = 24,
   parameter int          BW        = 8,
   parameter int          SLOTS     = 32,
   parameter int          WANDER_UI = 140,
   parameter logic [7:0]  IDLE      = 8'hFF,
   localparam int FB   = t1sb_pkg::frame_bits(CH, BW),
   localparam int PAIR = 2 * FB,
   localparam int PW   = $clog2(PAIR),
   localparam int AW   = $clog2(2 * CH),
   localparam int SW   = $clog2(SLOTS),
   localparam int LO   = FB - WANDER_UI,
   localparam int HI   = FB + WANDER_UI
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slot_en,
   input  logic          sfs,
   input  logic          clr,
   input  logic [PW-1:0] wpos,
   input  logic          synced,
   output logic [AW-1:0] raddr_o,
   input  logic [BW-1:0] rdata,
   output logic [BW-1:0] data_o,
   output logic          valid_o,
   output logic          slip_o,
   output logic          drop_o,
   output logic          seen_o
);

   import t1sb_pkg::*;

   logic [SW-1:0] slot_q, slot_cur;
   logic          rpar, newpar, par_use;
   logic [PW:0]   dsum, phase;
   logic          boundary, under, over, slip_now, is_chan;
   slip_dir_e     dir;

   assign slot_cur = sfs ? '0 : ((slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + 1'b1);
   assign boundary = slot_en && (slot_cur == '0);
   assign newpar   = ~rpar;
   assign dsum     = {1'b0, wpos} + (PW+1)'(PAIR) - (newpar ? (PW+1)'(FB) : '0);
   assign phase    = (dsum >= (PW+1)'(PAIR)) ? dsum - (PW+1)'(PAIR) : dsum;
   assign under    = synced && (phase < (PW+1)'(LO));
   assign over     = synced && (phase > (PW+1)'(HI));
   assign slip_now = boundary && (under || over);
   assign dir      = over ? SLIP_DELETE : SLIP_REPEAT;
   assign par_use  = (boundary && !(under || over)) ? newpar : rpar;
   assign is_chan  = ({1'b0, slot_cur} < (SW+1)'(CH));
   assign raddr_o  = !is_chan ? '0 :
                     (par_use ? AW'(CH) + AW'(slot_cur) : AW'(slot_cur));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q  <= SW'(SLOTS - 1);
         rpar    <= 1'b1;
         data_o  <= '0;
         valid_o <= 1'b0;
         slip_o  <= 1'b0;
         drop_o  <= 1'b0;
         seen_o  <= 1'b0;
      end else begin
         valid_o <= slot_en;
         slip_o  <= slip_now;
         if (slot_en) begin
            slot_q <= slot_cur;
            rpar   <= par_use;
            data_o <= is_chan ? rdata : IDLE[BW-1:0];
         end
         if (slip_now) drop_o <= dir;
         if (slip_now)      seen_o <= 1'b1;
         else if (clr)      seen_o <= 1'b0;
      end
   end

   AST_VALID_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      slot_en |=> valid_o); // R3
   AST_SLIP_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      slip_o |-> valid_o); // R9
   AST_SLIP_KEEPS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      slip_o |-> (rpar == $past(rpar))); // R7
   AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      slip_o |-> seen_o); // R10
   AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr) && !slip_o) |-> !seen_o); // R10
   AST_NO_SLIP_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
      !synced |=> !slip_o); // R11

endmodule

// File: rtl/t1_rx_slip_buf.sv
module t1_rx_slip_buf #(
   parameter int         CH        = 24,
   parameter int         BW        = 8,
   parameter int         SLOTS     = 32,
   parameter int         WANDER_UI = 140,
   parameter logic [7:0] IDLE      = 8'hFF,
   parameter bit         MSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_bit_en,
   input  logic          line_fs,
   input  logic          line_bit,
   input  logic          sys_slot_en,
   input  logic          sys_fs,
   input  logic          slip_clr,
   output logic [BW-1:0] pcm_data_o,
   output logic          pcm_valid_o,
   output logic          slip_o,
   output logic          slip_drop_o,
   output logic          slip_seen_o
);

   localparam int FB    = t1sb_pkg::frame_bits(CH, BW);
   localparam int PW    = $clog2(2 * FB);
   localparam int DEPTH = 2 * CH;
   localparam int AW    = $clog2(DEPTH);

   initial begin
      assert (BW >= 2 && BW <= 8) else $error("BW must be 2..8");
      assert (SLOTS >= CH) else $error("SLOTS must cover all channels");
      assert (WANDER_UI > 0 && WANDER_UI < FB) else $error("WANDER_UI out of range");
   end

   logic          we, synced;
   logic [AW-1:0] waddr, raddr;
   logic [BW-1:0] wdata, rdata;
   logic [PW-1:0] wpos;

   t1sb_wr #(.CH(CH), .BW(BW), .MSB_FIRST(MSB_FIRST)) wr_i (
      .clk(clk), .rst_n(rst_n), .bit_en(line_bit_en), .fs(line_fs), .bit_i(line_bit),
      .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .wpos_o(wpos), .synced_o(synced)
   );

   t1sb_store #(.DEPTH(DEPTH), .BW(BW)) store_i (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rdata)
   );

   t1sb_rd #(.CH(CH), .BW(BW), .SLOTS(SLOTS), .WANDER_UI(WANDER_UI), .IDLE(IDLE)) rd_i (
      .clk(clk), .rst_n(rst_n), .slot_en(sys_slot_en), .sfs(sys_fs), .clr(slip_clr),
      .wpos(wpos), .synced(synced), .raddr_o(raddr), .rdata(rdata),
      .data_o(pcm_data_o), .valid_o(pcm_valid_o), .slip_o(slip_o),
      .drop_o(slip_drop_o), .seen_o(slip_seen_o)
   );

endmodule

// File: tb/t1_rx_slip_buf_tb_top.sv
module t1_rx_slip_buf_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_bit_en = 0, line_fs = 0, line_bit = 0;
   logic sys_slot_en = 0, sys_fs = 0, slip_clr = 0;
   logic [7:0] pcm_data_o;
   logic pcm_valid_o, slip_o, slip_drop_o, slip_seen_o;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   t1_rx_slip_buf dut_i (
      .clk(clk), .rst_n(rst_n), .line_bit_en(line_bit_en), .line_fs(line_fs),
      .line_bit(line_bit), .sys_slot_en(sys_slot_en), .sys_fs(sys_fs),
      .slip_clr(slip_clr), .pcm_data_o(pcm_data_o), .pcm_valid_o(pcm_valid_o),
      .slip_o(slip_o), .slip_drop_o(slip_drop_o), .slip_seen_o(slip_seen_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // scoreboard queues
   logic [7:0] exp_q[$];
   bit         slip_q[$];
   int         obs_slips = 0;

   // stimulus and model state
   int lc = 0, sc = 0, lf = 0, lp = 256;
   bit sys_on = 0;
   bit msync = 0, mwpar = 0, mrpar = 1;
   int mwbit = 0, mslot = 31, mwpos = 0;
   int nrep = 0, ndel = 0;
   logic [7:0] mmem [2][24];

   function automatic logic [7:0] pat(input int f, input int c);
      return 8'(f * 7 + c * 13 + 1);
   endfunction

   task automatic step();
      bit lb, lfs, bv, ss, sfs;
      int d, np, slot, k;
      @(negedge clk);
      lb  = (lc < 193);
      lfs = (lc == 0);
      if (lc == 0) bv = 1'b1;
      else if (lb) bv = pat(lf, (lc - 1) / 8)[7 - ((lc - 1) % 8)];
      else bv = 1'b0;
      ss  = sys_on && (sc % 8 == 0);
      sfs = sys_on && (sc == 0);
      line_bit_en = lb; line_fs = lfs; line_bit = bv;
      sys_slot_en = ss; sys_fs = sfs;
      // reader model sees state before this cycle's write
      if (ss) begin
         slot = sfs ? 0 : ((mslot == 31) ? 0 : mslot + 1);
         mslot = slot;
         if (slot == 0) begin
            np = !mrpar;
            if (msync) begin
               d = (mwpos + 386 - (np ? 193 : 0)) % 386;
               if (d < 53) begin slip_q.push_back(1'b0); nrep++; end
               else if (d > 333) begin slip_q.push_back(1'b1); ndel++; end
               else mrpar = np[0];
            end else mrpar = np[0];
         end
         exp_q.push_back(slot < 24 ? mmem[mrpar][slot] : 8'hFF);
      end
      // writer model
      if (lb) begin
         if (lfs) begin
            mwpar = msync ? !mwpar : 1'b0;
            msync = 1; mwbit = 0;
         end else if (msync) begin
            mwbit++;
            k = mwbit - 1;
            if (k % 8 == 7) mmem[mwpar][k / 8] = pat(lf, k / 8);
         end
      end
      mwpos = (mwpar ? 193 : 0) + mwbit;
      lc++;
      if (lc >= lp) begin lc = 0; lf++; end
      if (sys_on) sc = (sc + 1) % 256;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (pcm_valid_o) begin
            if (exp_q.size() == 0) check(0, "R3 unexpected byte", 1, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               check(pcm_data_o == e, "R2/R4 slot byte", pcm_data_o, e);
            end
         end
         if (slip_o) begin
            obs_slips++;
            if (slip_q.size() == 0) check(0, "R6 unexpected slip", 1, 0);
            else begin
               bit e;
               e = slip_q.pop_front();
               check(slip_drop_o == e, "R7/R8 slip direction", slip_drop_o, e);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         check(0, "watchdog", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < 2; p++) for (int c = 0; c < 24; c++) mmem[p][c] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(pcm_valid_o == 0, "R1 valid after reset", pcm_valid_o, 0);
      check(slip_o == 0, "R1 slip after reset", slip_o, 0);
      check(slip_seen_o == 0, "R1 sticky after reset", slip_seen_o, 0);
      check(slip_drop_o == 0, "R1 direction after reset", slip_drop_o, 0);
      rst_n = 1'b1;
      // R11: backplane running before any line frame start, no slip
      sys_on = 1; lc = 300; lp = 100000;
      for (int i = 0; i < 600; i++) step();
      check(obs_slips == 0, "R11 no slip before line sync", obs_slips, 0);
      // restart cleanly for the locked phase
      sys_on = 0; line_bit_en = 0; sys_slot_en = 0; sys_fs = 0; line_fs = 0;
      @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      exp_q.delete(); slip_q.delete();
      msync = 0; mwpar = 0; mrpar = 1; mwbit = 0; mslot = 31; mwpos = 0;
      for (int p = 0; p < 2; p++) for (int c = 0; c < 24; c++) mmem[p][c] = 8'h00;
      lc = 0; lf = 0; lp = 256; sc = 0;
      // R5: one line frame first, then the backplane starts aligned
      for (int i = 0; i < 256; i++) step();
      sys_on = 1; sc = 0;
      for (int i = 0; i < 8 * 256; i++) step();
      check(obs_slips == 0, "R6 locked timing no slips", obs_slips, 0);
      check(slip_seen_o == 0, "R6 locked sticky clear", slip_seen_o, 0);
      // R7: line slower -> writer falls behind -> repeat
      lp = 264;
      for (int i = 0; i < 30 * 256; i++) step();
      check(nrep >= 1, "R7 repeat provoked", nrep, 1);
      // R8: line faster -> writer runs ahead -> delete
      lp = 240;
      for (int i = 0; i < 30 * 256; i++) step();
      check(ndel >= 1, "R8 delete provoked", ndel, 1);
      sys_on = 0; lp = 100000; lc = 300;
      for (int i = 0; i < 4; i++) step();
      check(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
      check(slip_q.size() == 0, "R9 all slips reported", slip_q.size(), 0);
      check(obs_slips == nrep + ndel, "R9 slip pulse count", obs_slips, nrep + ndel);
      // R10 sticky hold and clear
      check(slip_seen_o == 1, "R10 sticky held", slip_seen_o, 1);
      @(negedge clk); slip_clr = 1;
      @(negedge clk); slip_clr = 0;
      check(slip_seen_o == 0, "R10 sticky cleared", slip_seen_o, 0);
      @(negedge clk);
      check(slip_seen_o == 0, "R10 sticky stays clear", slip_seen_o, 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule